// File: doc/BRIEF.md
# Cache Line Fill Qualification and Invalidation Controller

This controller sits between a processor's bus unit and its on-chip cache. For each cacheable read it watches the cache-enable input (active low) and the two ready inputs (active low). It decides first whether the cycle grows into a multi-transfer line fill. At the end of the fill it decides whether the collected line may be written into the cache. Both decisions use the cache-enable level that was present one clock before the transfer in question. A one-stage pipeline register holds that sampled level.

The controller also turns an asynchronous, one-clock-wide flush request (active low) into a single synchronous whole-cache flush pulse. A flush that arrives while a fill is in progress cancels that fill's commit. When the external address strobe (active low) is seen, the controller captures the snoop address and raises an invalidate pulse for that address. Last, it works out the page-cacheability pins from the page attribute bits, the paging-enable bit and the cache-disable bit. It registers these pins like the other cycle outputs and stops driving them while the bus is held.

Top module: `fill_qual_ctrl`

## Requirements
- R1: After reset, fill_o, commit_o, flush_o, inv_o, pcd_o, pwt_o and pin_oe are all 0.
- R2: The first transfer of a cycle is the first clock edge with rdy_n=0 or brdy_n=0 while cyc_rd=1. If, at that edge, ken_n was 0 in the previous clock and the cycle is cacheable, fill_o goes to 1 in the following cycle.
- R3: If ken_n was 1 in the clock before the first transfer, no fill starts and commit_o stays 0 for the rest of that cycle.
- R4: A cycle is cacheable unless pg_en=1 and pcd_attr=1. With pg_en=0, pcd_attr has no effect on whether a fill starts.
- R5: A fill ends at its LINE_BEATS-th transfer (default 4). Transfers do not have to be in consecutive clocks, and either ready counts. fill_o returns to 0 in the next cycle. commit_o is a one-cycle pulse in that same cycle when ken_n was 0 in the clock before the last transfer.
- R6: If ken_n was 1 in the clock before the last transfer, the fill still ends and commit_o stays 0.
- R7: When flush_n is sampled at 0 on edge A, flush_o is 1 for exactly one cycle, following edge A+2. This holds even if flush_n stays low for several clocks.
- R8: A flush event that falls between the first transfer and the last transfer of a fill, including the edge of the last transfer itself, cancels that fill's commit. commit_o and flush_o are never 1 in the same cycle.
- R9: When eads_n is sampled at 0, inv_o is 1 in the next cycle and inv_addr holds the snoop_addr sampled at that edge.
- R10: One cycle after sampling, pcd_o = pg_en & pcd_attr & ~cd and pwt_o = pg_en & pwt_attr.
- R11: pin_oe is 0 in the cycle after bus_hold is sampled at 1, and 1 in the cycle after it is sampled at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_rd | input | 1 | A read cycle is in progress |
| ken_n | input | 1 | Cache enable, active low |
| rdy_n | input | 1 | Non-burst ready, active low |
| brdy_n | input | 1 | Burst ready, active low |
| flush_n | input | 1 | Asynchronous flush request, active low |
| eads_n | input | 1 | External address valid strobe, active low |
| snoop_addr | input | ADDR_W | Externally driven line address |
| pg_en | input | 1 | Paging enabled |
| cd | input | 1 | Cache-disable control bit |
| pcd_attr | input | 1 | Page cache-disable attribute |
| pwt_attr | input | 1 | Page write-through attribute |
| bus_hold | input | 1 | Bus is held by another master |
| fill_o | output | 1 | Line fill in progress |
| commit_o | output | 1 | Write the filled line into the cache |
| flush_o | output | 1 | Invalidate the whole cache |
| inv_o | output | 1 | Invalidate the line at inv_addr |
| inv_addr | output | ADDR_W | Captured snoop address |
| pcd_o | output | 1 | Page cache-disable pin value |
| pwt_o | output | 1 | Page write-through pin value |
| pin_oe | output | 1 | Drive enable for pcd_o and pwt_o |

## Verification
The case that needs care is a flush and the last transfer of a fill landing on the same clock edge. The synchronized flush event must stop the commit even though the cache-enable sample would otherwise allow it. The bench provokes this by pulling flush_n low for one clock during the second burst transfer. Counting the three synchronizer flops, the flush event then lines up exactly with the fourth ready. The bench judges the result in the cycle after that edge: flush_o must be 1 and commit_o must be 0, while the same vector without the flush commits.

// File: rtl/fq_pkg.sv
package fq_pkg;
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_FILL = 1'b1
    } fill_state_e;

    typedef struct packed {
        logic pcd;
        logic pwt;
        logic oe;
    } pin_state_t;
endpackage

// File: rtl/fq_flush_sync.sv
module fq_flush_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_n,
    output logic flush_evt,
    output logic flush_pulse
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] sh;
        logic             pulse;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sh    = {st_q.sh[DEPTH-2:0], flush_n};
        flush_evt  = st_q.sh[DEPTH-1] & ~st_q.sh[DEPTH-2];
        st_d.pulse = flush_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh    <= '1;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flush_pulse = st_q.pulse;
endmodule

// File: rtl/fq_fill_seq.sv
module fq_fill_seq
    import fq_pkg::*;
#(
    parameter int LINE_BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_rd,
    input  logic cacheable,
    input  logic ken_n,
    input  logic rdy_n,
    input  logic brdy_n,
    input  logic flush_evt,
    output logic fill_o,
    output logic commit_o
);
    localparam int BW = (LINE_BEATS > 2) ? $clog2(LINE_BEATS) : 1;
    localparam logic [BW-1:0] LAST = BW'(LINE_BEATS - 1);

    typedef struct packed {
        fill_state_e   state;
        logic [BW-1:0] beats;
        logic          seen;
        logic          ken_q;
        logic          cancel;
        logic          commit;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic xfer;

    always_comb begin
        st_d        = st_q;
        st_d.ken_q  = ken_n;
        st_d.commit = 1'b0;
        xfer        = ~rdy_n | ~brdy_n;

        if (!cyc_rd)   st_d.seen = 1'b0;
        else if (xfer) st_d.seen = 1'b1;

        case (st_q.state)
            FS_IDLE: begin
                if (cyc_rd && xfer && !st_q.seen && cacheable && !st_q.ken_q) begin
                    st_d.state  = FS_FILL;
                    st_d.beats  = BW'(1);
                    st_d.cancel = 1'b0;
                end
            end
            FS_FILL: begin
                if (xfer && st_q.beats == LAST) begin
                    st_d.state  = FS_IDLE;
                    st_d.beats  = '0;
                    st_d.commit = ~st_q.ken_q & ~st_q.cancel & ~flush_evt;
                    st_d.cancel = 1'b0;
                end else begin
                    if (xfer)      st_d.beats  = st_q.beats + BW'(1);
                    if (flush_evt) st_d.cancel = 1'b1;
                end
            end
            default: st_d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state  <= FS_IDLE;
            st_q.beats  <= '0;
            st_q.seen   <= 1'b0;
            st_q.ken_q  <= 1'b1;
            st_q.cancel <= 1'b0;
            st_q.commit <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fill_o   = (st_q.state == FS_FILL);
    assign commit_o = st_q.commit;
endmodule

// File: rtl/fq_page_attr.sv
module fq_page_attr
    import fq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pg_en,
    input  logic cd,
    input  logic pcd_attr,
    input  logic pwt_attr,
    input  logic bus_hold,
    output logic cache_ok,
    output logic pcd_o,
    output logic pwt_o,
    output logic pin_oe
);
    pin_state_t st_d, st_q;

    always_comb begin
        cache_ok = ~(pg_en & pcd_attr);
        st_d.pcd = pg_en & pcd_attr & ~cd;
        st_d.pwt = pg_en & pwt_attr;
        st_d.oe  = ~bus_hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pcd_o  = st_q.pcd;
    assign pwt_o  = st_q.pwt;
    assign pin_oe = st_q.oe;
endmodule

// File: rtl/fq_snoop.sv
module fq_snoop #(
    parameter int ADDR_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eads_n,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              inv_o,
    output logic [ADDR_W-1:0] inv_addr
);
    typedef struct packed {
        logic              inv;
        logic [ADDR_W-1:0] addr;
    } snoop_state_t;

    snoop_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.inv = ~eads_n;
        if (!eads_n) st_d.addr = snoop_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign inv_o    = st_q.inv;
    assign inv_addr = st_q.addr;
endmodule

// File: rtl/fill_qual_ctrl.sv
module fill_qual_ctrl #(
    parameter int ADDR_W      = 28,
    parameter int LINE_BEATS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_rd,
    input  logic              ken_n,
    input  logic              rdy_n,
    input  logic              brdy_n,
    input  logic              flush_n,
    input  logic              eads_n,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              pg_en,
    input  logic              cd,
    input  logic              pcd_attr,
    input  logic              pwt_attr,
    input  logic              bus_hold,
    output logic              fill_o,
    output logic              commit_o,
    output logic              flush_o,
    output logic              inv_o,
    output logic [ADDR_W-1:0] inv_addr,
    output logic              pcd_o,
    output logic              pwt_o,
    output logic              pin_oe
);
    logic flush_evt;
    logic cache_ok;

    fq_flush_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .flush_n(flush_n),
        .flush_evt(flush_evt), .flush_pulse(flush_o)
    );

    fq_page_attr u_page (
        .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .cd(cd),
        .pcd_attr(pcd_attr), .pwt_attr(pwt_attr), .bus_hold(bus_hold),
        .cache_ok(cache_ok), .pcd_o(pcd_o), .pwt_o(pwt_o), .pin_oe(pin_oe)
    );

    fq_fill_seq #(.LINE_BEATS(LINE_BEATS)) u_seq (
        .clk(clk), .rst_n(rst_n), .cyc_rd(cyc_rd), .cacheable(cache_ok),
        .ken_n(ken_n), .rdy_n(rdy_n), .brdy_n(brdy_n), .flush_evt(flush_evt),
        .fill_o(fill_o), .commit_o(commit_o)
    );

    fq_snoop #(.ADDR_W(ADDR_W)) u_snoop (
        .clk(clk), .rst_n(rst_n), .eads_n(eads_n), .snoop_addr(snoop_addr),
        .inv_o(inv_o), .inv_addr(inv_addr)
    );
endmodule

// File: rtl/fill_qual_ctrl_chk.sv
module fill_qual_ctrl_chk #(
    parameter int ADDR_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eads_n,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              pg_en,
    input logic              cd,
    input logic              bus_hold,
    input logic              fill_o,
    input logic              commit_o,
    input logic              flush_o,
    input logic              inv_o,
    input logic [ADDR_W-1:0] inv_addr,
    input logic              pcd_o,
    input logic              pwt_o,
    input logic              pin_oe
);
    // R5: a commit only ever closes a fill that was running
    assert_commit_after_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(fill_o));

    // R7: the flush pulse lasts one cycle
    assert_flush_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    // R8: flush and commit never coincide
    assert_no_commit_on_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && flush_o));

    // R9: invalidate follows a strobe and carries its address
    assert_inv_from_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_o |-> ($past(!eads_n) && inv_addr == $past(snoop_addr)));

    // R10: cache-disable masks pcd, paging gates pwt
    assert_pcd_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pcd_o |-> ($past(!cd) && $past(pg_en)));
    assert_pwt_paging_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwt_o |-> $past(pg_en));

    // R11: pins released while the bus is held
    assert_oe_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> $past(!bus_hold));
endmodule

bind fill_qual_ctrl fill_qual_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .eads_n(eads_n), .snoop_addr(snoop_addr),
    .pg_en(pg_en), .cd(cd), .bus_hold(bus_hold), .fill_o(fill_o),
    .commit_o(commit_o), .flush_o(flush_o), .inv_o(inv_o), .inv_addr(inv_addr),
    .pcd_o(pcd_o), .pwt_o(pwt_o), .pin_oe(pin_oe)
);

// File: tb/fill_qual_ctrl_tb.sv
module fill_qual_ctrl_tb;
    localparam int AW = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_rd = 0, ken_n = 1, rdy_n = 1, brdy_n = 1, flush_n = 1, eads_n = 1;
    logic [AW-1:0] snoop_addr = '0;
    logic pg_en = 0, cd = 0, pcd_attr = 0, pwt_attr = 0, bus_hold = 0;
    logic fill_o, commit_o, flush_o, inv_o, pcd_o, pwt_o, pin_oe;
    logic [AW-1:0] inv_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fill_qual_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_rd(cyc_rd), .ken_n(ken_n), .rdy_n(rdy_n),
        .brdy_n(brdy_n), .flush_n(flush_n), .eads_n(eads_n), .snoop_addr(snoop_addr),
        .pg_en(pg_en), .cd(cd), .pcd_attr(pcd_attr), .pwt_attr(pwt_attr),
        .bus_hold(bus_hold), .fill_o(fill_o), .commit_o(commit_o), .flush_o(flush_o),
        .inv_o(inv_o), .inv_addr(inv_addr), .pcd_o(pcd_o), .pwt_o(pwt_o), .pin_oe(pin_oe)
    );

    // bits: [6] pg_en [5] pcd_attr [4] ken first [3] ken last [2] flush
    //       [1] expected fill [0] expected commit
    localparam logic [6:0] VEC [8] = '{
        7'b1000011, 7'b1001010, 7'b1010000, 7'b1100000,
        7'b0100011, 7'b1000110, 7'b1010000, 7'b0000011
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        // R1: reset state
        check("R1 fill", 32'(fill_o), 0);
        check("R1 commit", 32'(commit_o), 0);
        check("R1 flush", 32'(flush_o), 0);
        check("R1 inv", 32'(inv_o), 0);
        check("R1 pins", {29'd0, pcd_o, pwt_o, pin_oe}, 0);
        rst_n = 1'b1;
        step(3);

        foreach (VEC[i]) begin
            logic [6:0] v;
            v = VEC[i];
            pg_en = v[6]; pcd_attr = v[5]; ken_n = v[4]; cyc_rd = 1;
            step(1);
            brdy_n = 0;                         // T1 at next edge
            step(1);
            check($sformatf("R2/R3/R4 fill start v%0d", i), 32'(fill_o), 32'(v[1]));
            if (v[2]) flush_n = 0;              // sampled at T2
            step(1);
            flush_n = 1;
            ken_n = v[3];                       // sampled at T3, used at T4
            step(2);
            brdy_n = 1; cyc_rd = 0; ken_n = 1;
            check($sformatf("R5/R6/R8 commit v%0d", i), 32'(commit_o), 32'(v[0]));
            check($sformatf("R5 fill end v%0d", i), 32'(fill_o), 0);
            check($sformatf("R8 flush coincide v%0d", i), 32'(flush_o), 32'(v[2]));
            step(1);
            check($sformatf("R5 commit pulse v%0d", i), 32'(commit_o), 0);
            step(4);
        end

        // R5: transfers with wait states, mixed ready kinds
        pg_en = 0; pcd_attr = 0; ken_n = 0; cyc_rd = 1;
        step(1);
        rdy_n = 0; step(1); rdy_n = 1;          // T1
        step(1);
        brdy_n = 0; step(2); brdy_n = 1;        // T2, T3
        step(2);
        check("R5 fill holds across gap", 32'(fill_o), 1);
        check("R5 no early commit", 32'(commit_o), 0);
        rdy_n = 0; step(1); rdy_n = 1; cyc_rd = 0; ken_n = 1;  // T4
        check("R5 gap commit", 32'(commit_o), 1);
        check("R5 gap fill end", 32'(fill_o), 0);
        step(4);

        // R7: held-low flush yields one pulse
        flush_n = 0;
        step(2);
        check("R7 flush not yet", 32'(flush_o), 0);
        step(1);
        check("R7 flush pulse", 32'(flush_o), 1);
        step(1);
        check("R7 flush single", 32'(flush_o), 0);
        flush_n = 1;
        step(4);

        // R9: snoop invalidate
        eads_n = 0; snoop_addr = 28'hABC1234;
        step(1);
        eads_n = 1; snoop_addr = 28'h0000555;
        check("R9 inv", 32'(inv_o), 1);
        check("R9 addr", 32'(inv_addr), 32'h0ABC1234);
        step(1);
        check("R9 inv drop", 32'(inv_o), 0);

        // R10: page pins over all attribute combinations
        for (int k = 0; k < 16; k++) begin
            pg_en = k[3]; pcd_attr = k[2]; pwt_attr = k[1]; cd = k[0];
            step(1);
            check($sformatf("R10 pcd k%0d", k), 32'(pcd_o), 32'(k[3] & k[2] & ~k[0]));
            check($sformatf("R10 pwt k%0d", k), 32'(pwt_o), 32'(k[3] & k[1]));
        end

        // R11: bus hold releases pins
        check("R11 oe on", 32'(pin_oe), 1);
        bus_hold = 1;
        step(1);
        check("R11 oe off", 32'(pin_oe), 0);
        bus_hold = 0;
        step(1);
        check("R11 oe back", 32'(pin_oe), 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule